// File: doc/BRIEF.md
# Refill Holding Buffer for a Non-Blocking Data Cache

This block sits between a memory controller and a data cache. A refill, meaning a line address plus the data returned for it, can come back from memory while the cache is still busy writing results to the core. In that case the controller issues a store command to this buffer instead of stalling. The buffer keeps the address and the data together as one entry, so the cache can finish its current work and later pick the refill up with its address attached. Because of this, one outstanding miss does not block the other threads that use the cache.

Entries leave in the order they arrived, from a circular store of `DEPTH` slots. The oldest pending entry is always shown on the cache side. The cache consumes it with a one-cycle pop once it is free.

Both data paths follow valid/ready rules:

- **Controller side.** `mc_store` is the valid and `!buf_full` is the ready. A store made while `buf_full` is high is dropped, so the controller must hold the refill until `buf_full` falls.
- **Cache side.** `head_valid` is the valid and `head_pop` is the ready. The cache may hold off popping for as long as it likes. The head entry stays stable until it is popped.

Top module: `refill_stash`

## Requirements
- R1: A synchronous active-high `rst` empties the buffer. In the cycle after the reset edge, `head_valid` and `buf_full` are both 0.
- R2: A cycle with `mc_store`=1 and `buf_full`=0 stores `mc_addr` and `mc_data` together as one new entry.
- R3: `head_valid` is 1 exactly when at least one entry is held.
- R4: `head_addr` and `head_data` show the oldest held entry combinationally. An entry stored into an empty buffer appears on them in the very next cycle.
- R5: A cycle with `head_pop`=1 and `head_valid`=1 removes the presented entry. Entries leave in the order they were stored.
- R6: `buf_full` is 1 exactly when `DEPTH` entries are held.
- R7: A store made while `buf_full`=1 is ignored. The count, the head entry and all stored contents are unchanged.
- R8: A pop made while `head_valid`=0 is ignored. The buffer stays empty.
- R9: A store and a pop in the same cycle, with the buffer neither empty nor full, both take effect. The count is unchanged and the order is preserved.
- R10: Order and contents stay correct across any number of wraps of the circular slot pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_store | input | 1 | Store command from the memory controller (valid) |
| mc_addr | input | ADDR_W | Line address of the refill |
| mc_data | input | DATA_W | Refill data |
| buf_full | output | 1 | All slots occupied; stores are dropped |
| head_addr | output | ADDR_W | Address of the oldest entry |
| head_data | output | DATA_W | Data of the oldest entry |
| head_valid | output | 1 | At least one entry pending |
| head_pop | input | 1 | Cache consumes the presented entry |

## Verification
- **Pointer errors.** A wrong read or write pointer shows up at the ports as a wrong `head_addr`/`head_data` pair. It appears one cycle after the faulty update, and at the latest when the affected entry reaches the head.
- **Count errors.** A wrong occupancy count shows up as `head_valid` or `buf_full` at the wrong level in the cycle after the bad update. It can also show as a lost or duplicated entry, which is visible once the buffer drains.
- **Bench model.** Every cycle, the bench compares all three outputs against a queue model. It drives directed full, empty and simultaneous cases, and also runs long random traffic that wraps the pointers many times.

// File: rtl/refill_stash_pkg.sv
package refill_stash_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'b00,
    ACT_POP  = 2'b01,
    ACT_PUSH = 2'b10,
    ACT_BOTH = 2'b11
  } stash_act_e;

  function automatic stash_act_e classify(input logic push, input logic pop);
    return stash_act_e'({push, pop});
  endfunction

endpackage

// File: rtl/refill_stash_ctrl.sv
module refill_stash_ctrl
  import refill_stash_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_fire,
  output logic             pop_fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] occ,
  output logic             is_full,
  output logic             is_empty
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP       = CNT_W'(DEPTH);

  stash_act_e act;

  assign is_full   = (occ == CAP);
  assign is_empty  = (occ == '0);
  assign push_fire = push_req && !is_full;
  assign pop_fire  = pop_req && !is_empty;
  assign act       = classify(push_fire, pop_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (push_fire) begin
      wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
    end else if (pop_fire) begin
      rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      unique case (act)
        ACT_PUSH: occ <= occ + 1'b1;
        ACT_POP:  occ <= occ - 1'b1;
        default:  occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/refill_stash_store.sv
module refill_stash_store #(
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
        slot_addr[i] <= wr_addr;
        slot_data[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_ptr == PTR_W'(j)) begin
        rd_addr = slot_addr[j];
        rd_data = slot_data[j];
      end
    end
  end

endmodule

// File: rtl/refill_stash.sv
module refill_stash #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_store,
  input  logic [ADDR_W-1:0] mc_addr,
  input  logic [DATA_W-1:0] mc_data,
  output logic              buf_full,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              head_valid,
  input  logic              head_pop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_fire;
  logic             pop_fire;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] occ;
  logic             is_full;
  logic             is_empty;

  refill_stash_ctrl #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .push_req (mc_store),
    .pop_req  (head_pop),
    .push_fire(push_fire),
    .pop_fire (pop_fire),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .occ      (occ),
    .is_full  (is_full),
    .is_empty (is_empty)
  );

  refill_stash_store #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) store_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (push_fire),
    .wr_ptr (wr_ptr),
    .wr_addr(mc_addr),
    .wr_data(mc_data),
    .rd_ptr (rd_ptr),
    .rd_addr(head_addr),
    .rd_data(head_data)
  );

  assign buf_full   = is_full;
  assign head_valid = !is_empty;

endmodule

// File: rtl/refill_stash_chk.sv
module refill_stash_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_store,
  input logic              head_pop,
  input logic              buf_full,
  input logic              head_valid,
  input logic [ADDR_W-1:0] head_addr,
  input logic [DATA_W-1:0] head_data,
  input logic [CNT_W-1:0]  occ
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!head_valid && !buf_full));

  // R3
  full_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    buf_full |-> head_valid);

  // R7
  full_store_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_full && mc_store && !head_pop) |=>
      (buf_full && $stable(head_addr) && $stable(head_data)));

  // R8
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!head_valid && head_pop && !mc_store) |=> !head_valid);

  // R9
  both_keep_count_chk: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !buf_full && mc_store && head_pop) |=> $stable(occ));

  // R5
  last_pop_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(1) && head_pop && !mc_store) |=> !head_valid);

  // R4
  idle_head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !head_pop) |=> ($stable(head_addr) && $stable(head_data)));

endmodule

bind refill_stash refill_stash_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mc_store  (mc_store),
  .head_pop  (head_pop),
  .buf_full  (buf_full),
  .head_valid(head_valid),
  .head_addr (head_addr),
  .head_data (head_data),
  .occ       (occ)
);

// File: tb/refill_stash_tb_top.sv
module refill_stash_tb_top;

  localparam int DEPTH  = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int EW     = ADDR_W + DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mc_store = 1'b0;
  logic [ADDR_W-1:0] mc_addr = '0;
  logic [DATA_W-1:0] mc_data = '0;
  logic              buf_full;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic              head_valid;
  logic              head_pop = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [EW-1:0] model [$];

  always #10 clk = ~clk;

  refill_stash #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .mc_store(mc_store), .mc_addr(mc_addr),
    .mc_data(mc_data), .buf_full(buf_full), .head_addr(head_addr),
    .head_data(head_data), .head_valid(head_valid), .head_pop(head_pop)
  );

  function automatic logic exp_valid();
    return model.size() > 0;
  endfunction

  function automatic logic exp_full();
    return model.size() == DEPTH;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [EW-1:0] got, input logic [EW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  // Compare all outputs with the model, called at a falling edge.
  task automatic observe(input string req);
    check(req, "head_valid", EW'(head_valid), EW'(exp_valid()));
    check(req, "buf_full", EW'(buf_full), EW'(exp_full()));
    if (model.size() > 0)
      check(req, "head entry", {head_addr, head_data}, model[0]);
  endtask

  // One cycle: check current outputs, drive inputs, update model, advance.
  task automatic step(input string req, input logic st, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic pp);
    bit can_push, can_pop;
    observe(req);
    mc_store = st; mc_addr = a; mc_data = d; head_pop = pp;
    can_push = st && !exp_full();
    can_pop  = pp && exp_valid();
    if (can_pop)  void'(model.pop_front());
    if (can_push) model.push_back({a, d});
    @(posedge clk);
    @(negedge clk);
    mc_store = 1'b0; head_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    // R1: state right after reset
    check("R1", "head_valid after reset", EW'(head_valid), '0);
    check("R1", "buf_full after reset", EW'(buf_full), '0);

    // R2 / R4: store into empty, visible next cycle
    step("R2", 1'b1, 12'hA11, 16'h1111, 1'b0);
    step("R4", 1'b0, '0, '0, 1'b0);
    // R6: fill to capacity
    step("R6", 1'b1, 12'hA22, 16'h2222, 1'b0);
    step("R6", 1'b1, 12'hA33, 16'h3333, 1'b0);
    step("R6", 1'b1, 12'hA44, 16'h4444, 1'b0);
    // R7: stores while full are dropped
    step("R7", 1'b1, 12'hBAD, 16'hDEAD, 1'b0);
    step("R7", 1'b1, 12'hBAE, 16'hBEEF, 1'b0);
    // R5: drain in order
    for (int k = 0; k < DEPTH; k++) step("R5", 1'b0, '0, '0, 1'b1);
    // R8: pops while empty are ignored
    step("R8", 1'b0, '0, '0, 1'b1);
    step("R8", 1'b0, '0, '0, 1'b1);
    step("R8", 1'b0, '0, '0, 1'b0);
    // R9: simultaneous store and pop at partial fill
    step("R9", 1'b1, 12'h501, 16'h0501, 1'b0);
    step("R9", 1'b1, 12'h502, 16'h0502, 1'b0);
    step("R9", 1'b1, 12'h503, 16'h0503, 1'b1);
    step("R9", 1'b1, 12'h504, 16'h0504, 1'b1);
    step("R9", 1'b0, '0, '0, 1'b1);
    step("R9", 1'b0, '0, '0, 1'b1);
    step("R9", 1'b0, '0, '0, 1'b0);
    // R10: repeated wraps with 3-deep bursts
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 3; k++)
        step("R10", 1'b1, ADDR_W'(r * 16 + k), DATA_W'(16'h7000 + r * 16 + k), 1'b0);
      for (int k = 0; k < 3; k++) step("R10", 1'b0, '0, '0, 1'b1);
    end
    // Random traffic, all rules together (R3, R5, R10)
    for (int n = 0; n < 2000; n++) begin
      logic st, pp;
      st = ($urandom % 100) < 55;
      pp = ($urandom % 100) < 50;
      step("R3", st, ADDR_W'($urandom), DATA_W'($urandom), pp);
    end
    // R1: reset in mid-traffic empties the buffer
    step("R1", 1'b1, 12'h0C1, 16'h00C1, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    observe("R1");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule